// File: doc/BRIEF.md
# Flash Line Cache Sequencer

This block is a read-only, memory-mapped window onto a serial flash device. It keeps one 1024-byte line of flash contents in a local byte buffer and answers 32-bit bus reads from it. A request whose address falls inside the cached line completes in the same cycle it is presented. Any other address is a miss. On a miss the block stalls the request and drives a byte-wide serial engine with a flash read command. It then clocks in a full line of data, records the new line base and serves the waiting request from the refreshed buffer.

A single 32-bit configuration word shapes the command. It holds the opcode, an optional mode byte with its enable, a dummy-byte count and a dual-device flag. The dual-device flag halves the bus address to form the flash address. Writing the configuration word drops the cached line. The byte engine is reached through a valid/ready transmit port and a receive strobe. The block keeps exactly one byte in flight: it sends a byte, then waits for the byte that comes back. An upper-page output steers the fill to the second device when the flash address runs past 16 MB.

Top module: `flash_line_cache`

## Requirements
- R1: After reset the configuration word equals 0x03A002EB: opcode 0xEB, mode byte 0xA0 enabled, two dummy bytes, single device. The cache holds no line, so rd_ready, tx_valid and upper_page are low and the first read is a miss.
- R2: A read hits when its address A satisfies base <= A <= base + 1020. rd_ready then rises in the same cycle, with rd_data = {buf[o+3], buf[o+2], buf[o+1], buf[o]} for o = A - base, and no bytes are sent to the engine.
- R3: A miss sends, in this order, the opcode from configuration bits [7:0] and then the 24-bit flash address as three bytes, most significant byte first.
- R4: When configuration bit 25 is 1, the byte from configuration bits [23:16] follows the address bytes. When bit 25 is 0, no mode byte is sent.
- R5: After the address (and mode) bytes, exactly N bytes of value 0x00 are sent, where N is configuration bits [10:8].
- R6: Bytes returned during the command phase are dropped. After the command, exactly 1024 bytes of 0x00 are sent, and the 1024 returned bytes are written to buffer positions 0 to 1023 in arrival order.
- R7: With configuration bit 30 = 1 the flash address is the bus address shifted right by one; otherwise it is the bus address. upper_page equals bit 24 of that flash address for the whole command and fill, and is low at all other times.
- R8: After a fill the line base equals the flash address times the device count (1 or 2), and the waiting request is then answered as a hit.
- R9: A configuration write makes every later address miss until the next fill. If the write lands during a fill, that fill does not validate the line, and the still-waiting request causes a fresh fill with the new settings.
- R10: rd_ready stays low from the start of a miss until its fill is done. tx_valid and tx_byte hold steady while tx_ready is low. A new byte is offered only after the previous byte's return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| rd_valid | input | 1 | Read request valid |
| rd_addr | input | AW | Read byte address |
| rd_ready | output | 1 | Read completes this cycle, rd_data valid |
| rd_data | output | 32 | Read data, little-endian byte order |
| tx_valid | output | 1 | Byte offered to the serial engine |
| tx_byte | output | 8 | Byte to send |
| tx_ready | input | 1 | Engine accepts tx_byte |
| rx_valid | input | 1 | Engine returns one byte |
| rx_byte | input | 8 | Returned byte |
| upper_page | output | 1 | Selects the upper flash device during a fill |

## Verification
The assertions rely on a few rules the surrounding logic must keep. The requester holds rd_addr steady until rd_ready. The engine raises rx_valid once for each accepted byte and only while the block is waiting for it. The bus address stays below 2^AW. The bench engine answers each accepted byte with a single one-cycle strobe one cycle after acceptance, and it stalls tx_ready on a fixed pattern. During the command phase it returns junk bytes and during the fill it returns a computed flash image, so a dropped, extra or misplaced byte corrupts the data the bench checks. The bench changes configuration only through the write port, including one write in the middle of a fill.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  // configuration word fields; positions are decoded by the command builder
  localparam logic [31:0] CFG_RESET   = 32'h03A0_02EB;
  localparam int          OPC_LSB     = 0;
  localparam int          DUMMY_LSB   = 8;
  localparam int          MODE_LSB    = 16;
  localparam int          MODE_EN_BIT = 25;
  localparam int          DUAL_BIT    = 30;
  localparam int          FLASH_AW    = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_TX,
    ST_CMD_RX,
    ST_FILL_TX,
    ST_FILL_RX
  } fc_state_e;
endpackage

// File: rtl/fc_cmd_gen.sv
`timescale 1ns/1ps
module fc_cmd_gen
  import fc_pkg::*;
#(
  parameter int LW = 10
) (
  input  logic [31:0]         cfg,
  input  logic [FLASH_AW-1:0] faddr,
  input  logic [LW-1:0]       idx,
  input  logic                fill,
  output logic [7:0]          byte_o,
  output logic                last_o
);
  logic [LW-1:0] cmd_len;
  logic          cfg_unused;

  assign cfg_unused = ^{cfg[31:26], cfg[24], cfg[15:11]};

  // opcode + 3 address bytes + optional mode byte + dummy bytes
  assign cmd_len = LW'(4) + LW'(cfg[MODE_EN_BIT]) + LW'(cfg[DUMMY_LSB +: 3]);
  assign last_o  = (idx == cmd_len - LW'(1));

  always_comb begin
    byte_o = 8'h00;
    if (!fill) begin
      if (idx == LW'(0))      byte_o = cfg[OPC_LSB +: 8];
      else if (idx == LW'(1)) byte_o = faddr[23:16];
      else if (idx == LW'(2)) byte_o = faddr[15:8];
      else if (idx == LW'(3)) byte_o = faddr[7:0];
      else if (idx == LW'(4) && cfg[MODE_EN_BIT]) byte_o = cfg[MODE_LSB +: 8];
    end
  end
endmodule

// File: rtl/fc_line_buf.sv
`timescale 1ns/1ps
module fc_line_buf #(
  parameter int LINE = 1024,
  localparam int LW  = $clog2(LINE)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [LW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [LW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [7:0] mem [LINE];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rdata[8*g +: 8] = mem[raddr + LW'(g)];
  end
endmodule

// File: rtl/fc_ctrl.sv
`timescale 1ns/1ps
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int AW   = 26,
  parameter int LINE = 1024,
  localparam int LW  = $clog2(LINE),
  localparam int BW  = AW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         cfg,
  input  logic                cfg_we,
  input  logic                rd_valid,
  input  logic [AW-1:0]       rd_addr,
  input  logic                tx_ready,
  input  logic                rx_valid,
  input  logic                cmd_last,
  output fc_state_e           st,
  output logic [LW-1:0]       cnt,
  output logic [31:0]         snap,
  output logic [FLASH_AW-1:0] faddr,
  output logic                upper,
  output logic                hit,
  output logic [LW-1:0]       off
);
  fc_state_e           st_q, st_d;
  logic [LW-1:0]       cnt_q, cnt_d;
  logic [31:0]         snap_q, snap_d;
  logic [FLASH_AW-1:0] fa_q, fa_d;
  logic                up_q, up_d;
  logic [AW-1:0]       pend_q, pend_d;
  logic                stale_q, stale_d;
  logic [AW:0]         base_q, base_d;

  logic                dual;
  logic [FLASH_AW-1:0] fa_lo;
  logic                fa_up;
  logic [AW-1:0]       base_new;
  logic [BW-1:0]       req_w, lo_w, hi_w;

  // base carries one spare bit so the all-ones invalid value never matches
  assign req_w = BW'(rd_addr);
  assign lo_w  = BW'(base_q);
  assign hi_w  = lo_w + BW'(LINE - 4);
  assign hit   = (req_w >= lo_w) && (req_w <= hi_w);
  assign off   = rd_addr[LW-1:0] - base_q[LW-1:0];

  assign dual     = cfg[DUAL_BIT];
  assign fa_lo    = dual ? rd_addr[FLASH_AW:1] : rd_addr[FLASH_AW-1:0];
  assign fa_up    = dual ? rd_addr[FLASH_AW+1] : rd_addr[FLASH_AW];
  assign base_new = dual ? {rd_addr[AW-1:1], 1'b0} : rd_addr;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    snap_d  = snap_q;
    fa_d    = fa_q;
    up_d    = up_q;
    pend_d  = pend_q;
    stale_d = stale_q;
    base_d  = base_q;
    unique case (st_q)
      ST_IDLE: if (rd_valid && !hit) begin
        st_d    = ST_CMD_TX;
        cnt_d   = '0;
        snap_d  = cfg;
        fa_d    = fa_lo;
        up_d    = fa_up;
        pend_d  = base_new;
        stale_d = 1'b0;
      end
      ST_CMD_TX: if (tx_ready) st_d = ST_CMD_RX;
      ST_CMD_RX: if (rx_valid) begin
        st_d  = cmd_last ? ST_FILL_TX : ST_CMD_TX;
        cnt_d = cmd_last ? '0 : cnt_q + LW'(1);
      end
      ST_FILL_TX: if (tx_ready) st_d = ST_FILL_RX;
      ST_FILL_RX: if (rx_valid) begin
        if (cnt_q == LW'(LINE - 1)) begin
          st_d = ST_IDLE;
          up_d = 1'b0;
          if (!stale_q) base_d = {1'b0, pend_q};
        end else begin
          st_d  = ST_FILL_TX;
          cnt_d = cnt_q + LW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    // configuration writes win over a completing fill
    if (cfg_we) begin
      base_d = '1;
      if (st_d != ST_IDLE) stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      snap_q  <= '0;
      fa_q    <= '0;
      up_q    <= 1'b0;
      pend_q  <= '0;
      stale_q <= 1'b0;
      base_q  <= '1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      snap_q  <= snap_d;
      fa_q    <= fa_d;
      up_q    <= up_d;
      pend_q  <= pend_d;
      stale_q <= stale_d;
      base_q  <= base_d;
    end
  end

  assign st    = st_q;
  assign cnt   = cnt_q;
  assign snap  = snap_q;
  assign faddr = fa_q;
  assign upper = up_q;

  // R7: the device select is only asserted while a line transfer is running
  a_r7_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !up_q);

  // R9: right after a configuration write no line is valid
  a_r9_base_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (base_q == '1));
endmodule

// File: rtl/flash_line_cache.sv
`timescale 1ns/1ps
module flash_line_cache
  import fc_pkg::*;
#(
  parameter int AW   = 26,
  parameter int LINE = 1024,
  localparam int LW  = $clog2(LINE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic [31:0]   rd_data,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          upper_page
);
  logic [31:0]         cfg_q, cfg_d;
  fc_state_e           st;
  logic [LW-1:0]       cnt, off;
  logic [31:0]         snap;
  logic [FLASH_AW-1:0] faddr;
  logic                hit, cmd_last, buf_we;

  assign cfg_d = cfg_we ? cfg_wdata : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  fc_ctrl #(.AW(AW), .LINE(LINE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .cfg_we(cfg_we),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .cmd_last(cmd_last), .st(st), .cnt(cnt),
    .snap(snap), .faddr(faddr), .upper(upper_page), .hit(hit), .off(off)
  );

  fc_cmd_gen #(.LW(LW)) gen_i (
    .cfg(snap), .faddr(faddr), .idx(cnt), .fill(st == ST_FILL_TX),
    .byte_o(tx_byte), .last_o(cmd_last)
  );

  assign buf_we = (st == ST_FILL_RX) && rx_valid;

  fc_line_buf #(.LINE(LINE)) buf_i (
    .clk(clk), .we(buf_we), .waddr(cnt), .wdata(rx_byte),
    .raddr(off), .rdata(rd_data)
  );

  assign tx_valid = (st == ST_CMD_TX) || (st == ST_FILL_TX);
  assign rd_ready = (st == ST_IDLE) && rd_valid && hit;

  // R10: an offered byte is held until the engine takes it
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R10: no read is answered while bytes are still moving
  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !tx_valid);

  // R6: fill-phase bytes are all zero
  a_r6_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && st == ST_FILL_TX) |-> (tx_byte == 8'h00));

  // R7: a served read never overlaps the upper-device select
  a_r7_no_upper_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !upper_page);

  // R9: a configuration write leaves no line to hit in the next cycle
  a_r9_cfg_miss: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !rd_ready);
endmodule

// File: tb/flash_line_cache_tb_top.sv
`timescale 1ns/1ps
module flash_line_cache_tb_top;
  localparam int AW   = 26;
  localparam int LINE = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic          rd_valid;
  logic [AW-1:0] rd_addr;
  logic          rd_ready;
  logic [31:0]   rd_data;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          tx_ready;
  logic          rx_valid;
  logic [7:0]    rx_byte;
  logic          upper_page;

  always #4 clk = ~clk;

  flash_line_cache #(.AW(AW), .LINE(LINE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .upper_page(upper_page)
  );

  int checks = 0;
  int errors = 0;

  // engine model state
  int          fills = 0;
  int          tr_idx = 0;
  int          tr_cmd = 0;
  int          fill_bad = 0;
  int          nstall = 0;
  int          cmd_len_cur;
  logic [31:0] cfg_cur;
  logic [7:0]  cap [16];
  logic [23:0] fa_tr;
  logic        up_tr;
  logic [7:0]  resp;
  bit          pending = 0;

  // bench model of the cached line
  bit            mvalid;
  logic [AW-1:0] mbase;
  logic [23:0]   mfa;
  logic          mup;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(input logic up, input logic [23:0] a);
    return a[7:0] + 8'(a[15:8] * 8'd3) + 8'(a[23:16] * 8'd5) + (up ? 8'h77 : 8'h00);
  endfunction

  // serial engine: one byte in flight, returns a byte one cycle after accept
  initial begin
    tx_ready = 1'b1;
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    forever begin
      @(negedge clk);
      rx_valid = 1'b0;
      tx_ready = 1'b1;
      if (!rst_n) begin
        pending = 0;
        tr_idx  = 0;
      end else if (pending) begin
        rx_valid = 1'b1;
        rx_byte  = resp;
        pending  = 0;
      end else if (tx_valid) begin
        nstall++;
        if (nstall % 7 == 3) begin
          tx_ready = 1'b0;
        end else begin
          if (tr_idx == 0) begin
            fills++;
            tr_cmd = cmd_len_cur;
          end
          if (tr_idx < 16) cap[tr_idx] = tx_byte;
          if (tr_idx == tr_cmd) begin
            fa_tr = {cap[1], cap[2], cap[3]};
            up_tr = upper_page;
          end
          if (tr_idx < tr_cmd) begin
            resp = 8'hC5 ^ 8'(tr_idx);
          end else begin
            if (tx_byte != 8'h00) fill_bad++;
            resp = fmem(upper_page, fa_tr + 24'(tr_idx - tr_cmd));
          end
          tr_idx++;
          if (tr_idx == tr_cmd + LINE) tr_idx = 0;
          pending = 1;
        end
      end
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we      = 1'b1;
    cfg_wdata   = v;
    cfg_cur     = v;
    cmd_len_cur = 4 + int'(v[25]) + int'(v[10:8]);
    mvalid      = 0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic model_miss(input logic [AW-1:0] a);
    if (cfg_cur[30]) begin
      mfa   = a[24:1];
      mup   = a[25];
      mbase = {a[AW-1:1], 1'b0};
    end else begin
      mfa   = a[23:0];
      mup   = a[24];
      mbase = a;
    end
    mvalid = 1;
  endtask

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [23:0] o;
    o = 24'(a - mbase);
    return {fmem(mup, mfa + o + 24'd3), fmem(mup, mfa + o + 24'd2),
            fmem(mup, mfa + o + 24'd1), fmem(mup, mfa + o)};
  endfunction

  task automatic wait_ready(output int n);
    n = 0;
    #1;
    while (!rd_ready && n < 20000) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (n >= 20000) chk(0, "watchdog waiting for rd_ready", 32'(n), 32'd0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    bit exp_hit;
    int f0, n;
    exp_hit = mvalid && (a >= mbase) && (longint'(a) <= longint'(mbase) + LINE - 4);
    if (!exp_hit) model_miss(a);
    f0 = fills;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = a;
    wait_ready(n);
    chk(rd_data == exp_word(a), {req, " data"}, rd_data, exp_word(a));
    chk((fills - f0) == (exp_hit ? 0 : 1), {req, " fill count"},
        32'(fills - f0), exp_hit ? 32'd0 : 32'd1);
    if (!exp_hit) begin
      chk(n >= 2 * LINE, "R10 ready held low through fill", 32'(n), 32'(2 * LINE));
      chk(fill_bad == 0, "R6 fill bytes zero", 32'(fill_bad), 32'd0);
      chk(up_tr == mup, "R7 upper_page during fill", 32'(up_tr), 32'(mup));
      chk(upper_page == 1'b0, "R7 upper_page low after fill", 32'(upper_page), 32'd0);
    end
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic check_cmd(input logic [7:0] opc, input logic [23:0] fa,
                           input bit men, input logic [7:0] mb, input int dum);
    bit zeros;
    chk(cap[0] == opc, "R3 opcode byte", 32'(cap[0]), 32'(opc));
    chk({cap[1], cap[2], cap[3]} == fa, "R3 address bytes", {8'h0, cap[1], cap[2], cap[3]},
        {8'h0, fa});
    if (men) chk(cap[4] == mb, "R4 mode byte", 32'(cap[4]), 32'(mb));
    zeros = 1;
    for (int i = 4 + int'(men); i < 4 + int'(men) + dum; i++)
      if (cap[i] != 8'h00) zeros = 0;
    chk(zeros, "R5 dummy bytes zero", 32'(zeros), 32'd1);
  endtask

  task automatic t_reset_state();
    #1;
    chk(rd_ready == 1'b0, "R1 rd_ready after reset", 32'(rd_ready), 32'd0);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", 32'(tx_valid), 32'd0);
    chk(upper_page == 1'b0, "R1 upper_page after reset", 32'(upper_page), 32'd0);
  endtask

  task automatic t_first_miss();
    do_read(26'h000100, "R1 first read misses");
    check_cmd(8'hEB, 24'h000100, 1'b1, 8'hA0, 2);
  endtask

  task automatic t_hits();
    do_read(26'h000100 + 26'd1020, "R2 top of window hit");
    do_read(26'h000103, "R2 unaligned hit");
    do_read(26'h000100 + 26'd1021, "R2 above window miss");
    check_cmd(8'hEB, 24'h0004FD, 1'b1, 8'hA0, 2);
    do_read(26'h0004FC, "R2 below base miss");
  endtask

  task automatic t_plain_cfg();
    write_cfg(32'h0000_000B);
    do_read(26'h0004FC, "R9 miss after config write");
    check_cmd(8'h0B, 24'h0004FC, 1'b0, 8'h00, 0);
    chk(cap[4] == 8'h00, "R4 no mode byte when disabled", 32'(cap[4]), 32'd0);
    do_read(26'h000500, "R2 hit after refill");
  endtask

  task automatic t_long_cmd();
    write_cfg(32'h023C_056B);
    do_read(26'h123456, "R5 long command read");
    check_cmd(8'h6B, 24'h123456, 1'b1, 8'h3C, 5);
  endtask

  task automatic t_dual();
    write_cfg(32'h4000_0003);
    do_read(26'h2000005, "R7 dual upper read");
    check_cmd(8'h03, 24'h000002, 1'b0, 8'h00, 0);
    do_read(26'h2000004 + 26'd1020, "R8 hit at doubled base");
    do_read(26'h0000100, "R7 dual lower read");
    check_cmd(8'h03, 24'h000080, 1'b0, 8'h00, 0);
  endtask

  task automatic t_stale();
    int f0, n;
    f0 = fills;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = 26'h040000;
    repeat (300) @(negedge clk);
    chk(rd_ready == 1'b0, "R10 stalled mid fill", 32'(rd_ready), 32'd0);
    write_cfg(32'h0000_0013);
    model_miss(26'h040000);
    wait_ready(n);
    chk((fills - f0) == 2, "R9 write during fill forces refill", 32'(fills - f0), 32'd2);
    chk(rd_data == exp_word(26'h040000), "R9 data after refill", rd_data,
        exp_word(26'h040000));
    check_cmd(8'h13, 24'h040000, 1'b0, 8'h00, 0);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    rst_n       = 1'b0;
    cfg_we      = 1'b0;
    cfg_wdata   = '0;
    rd_valid    = 1'b0;
    rd_addr     = '0;
    cfg_cur     = 32'h03A0_02EB;
    cmd_len_cur = 7;
    mvalid      = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_first_miss();
    t_hits();
    t_plain_cfg();
    t_long_cmd();
    t_dual();
    t_stale();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule